// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns the address of a PCI bus-master DMA transfer into a system physical address. Four programmable windows cover the 32-bit (single-address-cycle) space. Each window either maps a region directly onto a translated base or walks a one-level page table in memory (scatter-gather). Addresses above 4 GiB (dual-address-cycle) can go through a full-range pass-through window, or through the last window acting as a scatter-gather window with a fixed table layout. A control register can also carve a fixed hole out of the 32-bit space, where no translation ever succeeds.

A request is offered on a valid/ready port and accepted only while the block is idle. Translations that need no table entry answer on the cycle after acceptance. A scatter-gather translation issues exactly one 8-byte read on the memory port and waits for its response before it answers. Every answer is a one-cycle pulse that carries a hit flag and the translated address. Software programs and reads the window and control registers through a simple synchronous register port.

Top module: `dma_xlate_top`

## Requirements
- R1: The register port selects a register with `cfg_kind` (0 window base, 1 window mask, 2 translated base, 3 control) and `cfg_win`. A base register of windows 0 to 2 keeps bits [31:20] (base), bit 1 (scatter-gather) and bit 0 (enable). A mask register keeps bits [31:20]. A translated-base register keeps bits [34:10]. The control register keeps bit 5 (hole) and bit 6 (pass-through window). All other bits read back as zero. All registers reset to zero, except as R2 states.
- R2: The base register of window 3 always reads bit 1 as 1, from reset onward. It also keeps bit 39 (dual-address enable), along with bits [31:20] and bit 0.
- R3: A 32-bit address hits a window when that window is enabled and (addr & ~(mask | 0xFFFFF)) equals its base bits [31:20]. The lowest-numbered window that hits is the one used.
- R4: On a direct-mapped hit, the result is (tba & ~(mask | 0xFFFFF)) | (addr & (mask | 0xFFFFF)).
- R5: On a scatter-gather hit, one read goes out at (tba & ~(mask >> 10)) | ((addr & (mask | 0xFE000)) >> 10). With a valid entry, the result is ((pte & 0x3FFFFE) << 12) | addr[12:0].
- R6: A table entry whose bit 0 is clear gives a failed translation.
- R7: While control bit 5 is set, 32-bit addresses from 0x80000 to 0xFFFFF always fail. While it is clear, those addresses translate normally.
- R8: For 32-bit addresses, window 3 is tried only when its dual-address bit is clear.
- R9: While control bit 6 is set, addresses in [2^40, 2^41) hit with result addr[34:0]. Addresses outside that range, and all addresses while the bit is clear, never use this path.
- R10: Addresses from 0x800_0000_0000 to 0xFFF_FFFF_FFFF, when window 3 is enabled and dual-address enabled, read the entry at (tba & 0x7_FFC0_0000) | ((addr & 0xFFFF_E000) >> 10). The result is then formed as in R5 and R6.
- R11: Any address that no path translates fails. A failed answer has `rsp_hit` low and `rsp_addr` zero.
- R12: `req_ready` is high only while idle, and each answer is a single-cycle pulse. A scatter-gather translation issues exactly one memory read, holding its address stable until it is accepted.
- R13: A translation that needs no table read answers on the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window index of the register access |
| cfg_kind | input | 2 | Register kind: 0 base, 1 mask, 2 translated base, 3 control |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data, combinational from cfg_win/cfg_kind |
| req_valid | input | 1 | DMA address offered |
| req_ready | output | 1 | Block idle and accepting |
| req_addr | input | 44 | PCI DMA address |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 35 | Physical address of the table entry |
| mem_rsp_valid | input | 1 | Table entry returned |
| mem_rsp_data | input | 64 | Table entry value |
| rsp_valid | output | 1 | Translation answer pulse |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr | output | 35 | Translated physical address, zero on failure |

## Verification
The bench targets window priority when two windows overlap, and the edges of the hole: its lower bound, its upper bound and an address just below it. A design that checks windows in the wrong order returns the second window's address, and an off-by-one hole range lets 0xFFFFF through. It also covers the dual-address gating of window 3 in both directions, together with the masking of the table address and of the translated base on each path. A wrong shift or mask here shows up as a wrong memory read address, before any result comes back. Finally, it checks invalid table entries, the pass-through range boundary and the forced scatter-gather bit of window 3 on readback. A block that issued a second read or answered late would fail the read count or the latency check.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

    localparam int unsigned NWIN     = 4;
    localparam int unsigned WIN_IW   = $clog2(NWIN);
    localparam int unsigned PCI_AW   = 44;
    localparam int unsigned PA_W     = 35;
    localparam int unsigned CSR_W    = 64;
    localparam int unsigned PAGE_LO  = 13;
    localparam int unsigned FIELD_W  = 12;
    localparam int unsigned TBA_W    = PA_W - 10;

    localparam logic [1:0] KIND_BASE = 2'd0;
    localparam logic [1:0] KIND_MASK = 2'd1;
    localparam logic [1:0] KIND_TBA  = 2'd2;
    localparam logic [1:0] KIND_CTL  = 2'd3;

    typedef enum logic [1:0] {
        ACT_FAIL = 2'd0,
        ACT_DONE = 2'd1,
        ACT_PTE  = 2'd2
    } act_e;

    typedef struct packed {
        act_e             act;
        logic [PA_W-1:0]  addr;   // final address (DONE) or entry address (PTE)
    } decision_t;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic               sg;
        logic               en;
        logic               dac;
        logic [FIELD_W-1:0] mask;
        logic [TBA_W-1:0]   tba;
    } win_t;

    function automatic logic [PA_W-1:0] tba_full(win_t w);
        return {w.tba, 10'b0};
    endfunction

    function automatic logic [PA_W-1:0] ext_mask(win_t w);
        return {3'b000, w.mask, 20'hFFFFF};
    endfunction

    function automatic logic win_hit(win_t w, logic [31:0] a);
        return w.en && ((a[31:20] & ~w.mask) == w.base);
    endfunction

    function automatic logic [PA_W-1:0] direct_addr(win_t w, logic [31:0] a);
        return (tba_full(w) & ~ext_mask(w)) | ({3'b000, a} & ext_mask(w));
    endfunction

    function automatic logic [PA_W-1:0] sg_entry_addr(win_t w, logic [31:0] a);
        logic [31:0]     sel;
        logic [PA_W-1:0] idx;
        sel = {w.mask, 20'h0} | 32'h000F_E000;
        idx = {3'b000, (a & sel)} >> 10;
        return (tba_full(w) & ~{13'b0, w.mask, 10'b0}) | idx;
    endfunction

    function automatic logic [PA_W-1:0] dac_entry_addr(win_t w, logic [31:0] a);
        logic [PA_W-1:0] idx;
        idx = {3'b000, a[31:13], 13'b0} >> 10;
        return (tba_full(w) & 35'h7_FFC0_0000) | idx;
    endfunction

    function automatic logic [PA_W-1:0] entry_result(logic [20:0] frame, logic [PAGE_LO-1:0] lo);
        return {1'b0, frame, lo};
    endfunction

endpackage

// File: rtl/dma_xlate_csr.sv
module dma_xlate_csr
    import dma_xlate_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [WIN_IW-1:0]       cfg_win,
    input  logic [1:0]              cfg_kind,
    input  logic [CSR_W-1:0]        cfg_wdata,
    output logic [CSR_W-1:0]        cfg_rdata,
    output win_t [NWIN-1:0]         wins,
    output logic                    hole_en,
    output logic                    mon_en
);

    localparam int unsigned LAST = NWIN - 1;

    logic unused_wdata;
    assign unused_wdata = ^{cfg_wdata[63:40], cfg_wdata[38:35], cfg_wdata[9:7], cfg_wdata[4:2]};

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam bit IS_LAST = (i == LAST);
        logic hit_sel;
        assign hit_sel = cfg_wr && (cfg_win == WIN_IW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                wins[i].base <= '0;
                wins[i].en   <= 1'b0;
                wins[i].sg   <= IS_LAST;
                wins[i].dac  <= 1'b0;
                wins[i].mask <= '0;
                wins[i].tba  <= '0;
            end else if (hit_sel) begin
                case (cfg_kind)
                    KIND_BASE: begin
                        wins[i].base <= cfg_wdata[31:20];
                        wins[i].en   <= cfg_wdata[0];
                        wins[i].sg   <= IS_LAST ? 1'b1 : cfg_wdata[1];
                        wins[i].dac  <= IS_LAST ? cfg_wdata[39] : 1'b0;
                    end
                    KIND_MASK: wins[i].mask <= cfg_wdata[31:20];
                    KIND_TBA:  wins[i].tba  <= cfg_wdata[34:10];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hole_en <= 1'b0;
            mon_en  <= 1'b0;
        end else if (cfg_wr && cfg_kind == KIND_CTL) begin
            hole_en <= cfg_wdata[5];
            mon_en  <= cfg_wdata[6];
        end
    end

    always_comb begin
        win_t w;
        w = wins[cfg_win];
        case (cfg_kind)
            KIND_BASE: cfg_rdata = {24'b0, w.dac, 7'b0, w.base, 18'b0, w.sg, w.en};
            KIND_MASK: cfg_rdata = {32'b0, w.mask, 20'b0};
            KIND_TBA:  cfg_rdata = {29'b0, w.tba, 10'b0};
            default:   cfg_rdata = {57'b0, mon_en, hole_en, 5'b0};
        endcase
    end

endmodule

// File: rtl/dma_xlate_decode.sv
module dma_xlate_decode
    import dma_xlate_pkg::*;
(
    input  logic [PCI_AW-1:0]  addr,
    input  win_t [NWIN-1:0]    wins,
    input  logic               hole_en,
    input  logic               mon_en,
    output decision_t          dec
);

    localparam int unsigned LAST = NWIN - 1;

    logic sac, in_hole, in_mon, in_dac;

    assign sac     = (addr[PCI_AW-1:32] == '0);
    assign in_hole = hole_en && (addr[31:20] == '0) && addr[19];
    assign in_mon  = (addr[PCI_AW-1:40] == 4'h1);
    assign in_dac  = addr[PCI_AW-1];

    always_comb begin
        dec = '{act: ACT_FAIL, addr: '0};
        if (sac) begin
            if (!in_hole) begin
                // descending scan: lowest index that hits is written last
                for (int i = NWIN - 1; i >= 0; i--) begin
                    if (win_hit(wins[i], addr[31:0]) && !wins[i].dac) begin
                        if (wins[i].sg) begin
                            dec.act  = ACT_PTE;
                            dec.addr = sg_entry_addr(wins[i], addr[31:0]);
                        end else begin
                            dec.act  = ACT_DONE;
                            dec.addr = direct_addr(wins[i], addr[31:0]);
                        end
                    end
                end
            end
        end else if (in_mon && mon_en) begin
            dec.act  = ACT_DONE;
            dec.addr = addr[PA_W-1:0];
        end else if (in_dac && wins[LAST].en && wins[LAST].dac) begin
            dec.act  = ACT_PTE;
            dec.addr = dac_entry_addr(wins[LAST], addr[31:0]);
        end
    end

endmodule

// File: rtl/dma_xlate_ctrl.sv
module dma_xlate_ctrl
    import dma_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [PAGE_LO-1:0]   req_lo,
    input  decision_t            dec,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PA_W-1:0]      mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [CSR_W-1:0]     mem_rsp_data,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [PA_W-1:0]      rsp_addr
);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;

    state_e              st;
    logic [PA_W-1:0]     entry_q;
    logic [PAGE_LO-1:0]  lo_q;

    logic unused_rsp;
    assign unused_rsp = ^mem_rsp_data[CSR_W-1:22];

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_ISSUE);
    assign mem_req_addr  = entry_q;
    assign rsp_valid     = (st == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            entry_q  <= '0;
            lo_q     <= '0;
            rsp_hit  <= 1'b0;
            rsp_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    case (dec.act)
                        ACT_PTE: begin
                            entry_q <= dec.addr;
                            lo_q    <= req_lo;
                            st      <= ST_ISSUE;
                        end
                        ACT_DONE: begin
                            rsp_hit  <= 1'b1;
                            rsp_addr <= dec.addr;
                            st       <= ST_RESP;
                        end
                        default: begin
                            rsp_hit  <= 1'b0;
                            rsp_addr <= '0;
                            st       <= ST_RESP;
                        end
                    endcase
                end
                ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    rsp_hit  <= mem_rsp_data[0];
                    rsp_addr <= mem_rsp_data[0] ? entry_result(mem_rsp_data[21:1], lo_q) : '0;
                    st       <= ST_RESP;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_xlate_top.sv
module dma_xlate_top
    import dma_xlate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr,
    input  logic [1:0]           cfg_win,
    input  logic [1:0]           cfg_kind,
    input  logic [63:0]          cfg_wdata,
    output logic [63:0]          cfg_rdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [43:0]          req_addr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [34:0]          mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [63:0]          mem_rsp_data,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [34:0]          rsp_addr
);

    win_t [NWIN-1:0] wins;
    logic            hole_en;
    logic            mon_en;
    decision_t       dec;

    dma_xlate_csr u_csr (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_win   (cfg_win),
        .cfg_kind  (cfg_kind),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wins      (wins),
        .hole_en   (hole_en),
        .mon_en    (mon_en)
    );

    dma_xlate_decode u_dec (
        .addr    (req_addr),
        .wins    (wins),
        .hole_en (hole_en),
        .mon_en  (mon_en),
        .dec     (dec)
    );

    dma_xlate_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_lo        (req_addr[PAGE_LO-1:0]),
        .dec           (dec),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_addr      (rsp_addr)
    );

endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [43:0] req_addr,
    input logic        hole_en,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [34:0] mem_req_addr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [34:0] rsp_addr
);

    p_read_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_busy_answer_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_fail_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == 35'd0));

    p_next_step_r13: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (rsp_valid || mem_req_valid));

    p_hole_fail_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hole_en && req_addr[43:20] == 24'd0 && req_addr[19])
        |=> (rsp_valid && !rsp_hit));

endmodule

bind dma_xlate_top dma_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .hole_en       (hole_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_addr      (rsp_addr)
);

// File: tb/dma_xlate_top_bench.sv
module dma_xlate_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [1:0]  cfg_win;
    logic [1:0]  cfg_kind;
    logic [63:0] cfg_wdata;
    logic [63:0] cfg_rdata;
    logic        req_valid;
    logic        req_ready;
    logic [43:0] req_addr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [34:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [34:0] rsp_addr;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xlate_top u_dma_xlate_top (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_win(cfg_win), .cfg_kind(cfg_kind),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_csr(input logic [1:0] w, input logic [1:0] k, input logic [63:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_win = w; cfg_kind = k; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_csr(input logic [1:0] w, input logic [1:0] k, output logic [63:0] d);
        @(negedge clk);
        cfg_win = w; cfg_kind = k;
        #1 d = cfg_rdata;
    endtask

    // offers one address; serves at most the reads the block issues with entry value pte
    task automatic xlate(input logic [43:0] a, input logic [63:0] pte,
                         output logic hit, output logic [34:0] pa,
                         output int nrd, output logic [34:0] rd_addr, output int lat);
        hit = 1'b0; pa = '0; nrd = 0; rd_addr = '0; lat = 99;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k < 30; k++) begin
            if (rsp_valid) begin
                hit = rsp_hit; pa = rsp_addr; lat = k;
                break;
            end
            if (mem_req_valid) begin
                nrd++;
                rd_addr = mem_req_addr;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1; mem_rsp_data = pte;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic clear_all();
        for (int w = 0; w < 4; w++) begin
            wr_csr(w[1:0], 2'd0, 64'h0);
            wr_csr(w[1:0], 2'd1, 64'h0);
            wr_csr(w[1:0], 2'd2, 64'h0);
        end
        wr_csr(2'd0, 2'd3, 64'h0);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R12 ready after reset", {63'b0, req_ready}, 64'd1);
        chk("R12 no answer after reset", {63'b0, rsp_valid}, 64'd0);
        rd_csr(2'd0, 2'd0, d); chk("R1 reset base0", d, 64'h0);
        rd_csr(2'd2, 2'd2, d); chk("R1 reset tba2", d, 64'h0);
        rd_csr(2'd3, 2'd0, d); chk("R2 reset base3 sg bit", d, 64'h2);
    endtask

    task automatic t_csr();
        logic [63:0] d;
        wr_csr(2'd0, 2'd0, '1); rd_csr(2'd0, 2'd0, d); chk("R1 base0 fields", d, 64'hFFF0_0003);
        wr_csr(2'd1, 2'd1, '1); rd_csr(2'd1, 2'd1, d); chk("R1 mask1 fields", d, 64'hFFF0_0000);
        wr_csr(2'd2, 2'd2, '1); rd_csr(2'd2, 2'd2, d); chk("R1 tba2 fields", d, 64'h7_FFFF_FC00);
        wr_csr(2'd0, 2'd3, '1); rd_csr(2'd1, 2'd3, d); chk("R1 control fields", d, 64'h60);
        wr_csr(2'd3, 2'd0, '1); rd_csr(2'd3, 2'd0, d); chk("R2 base3 fields", d, 64'h80_FFF0_0003);
        wr_csr(2'd3, 2'd0, 64'h0); rd_csr(2'd3, 2'd0, d); chk("R2 base3 sg forced", d, 64'h2);
        clear_all();
    endtask

    task automatic t_direct_priority();
        logic hit; logic [34:0] pa, ra; int nrd, lat;
        wr_csr(2'd0, 2'd0, 64'h4000_0001);
        wr_csr(2'd0, 2'd1, 64'h0FF0_0000);
        wr_csr(2'd0, 2'd2, 64'h2_3000_0000);
        xlate(44'h0_4123_4567, 64'h0, hit, pa, nrd, ra, lat);
        chk("R4 direct hit", {63'b0, hit}, 64'd1);
        chk("R4 direct address", {29'b0, pa}, 64'h2_3123_4567);
        chk("R13 direct latency", lat, 64'd1);
        chk("R13 direct no read", nrd, 64'd0);
        xlate(44'h0_5000_0000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R11 miss flag", {63'b0, hit}, 64'd0);
        chk("R11 miss address", {29'b0, pa}, 64'h0);
        wr_csr(2'd1, 2'd0, 64'h4000_0001);
        wr_csr(2'd1, 2'd2, 64'h1_0000_0000);
        xlate(44'h0_4000_1234, 64'h0, hit, pa, nrd, ra, lat);
        chk("R3 lowest window wins", {29'b0, pa}, 64'h2_3000_1234);
        wr_csr(2'd0, 2'd0, 64'h4000_0000);
        xlate(44'h0_4000_1234, 64'h0, hit, pa, nrd, ra, lat);
        chk("R3 disabled window skipped", {29'b0, pa}, 64'h1_0000_1234);
        xlate(44'h0_4010_0000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R3 outside small window", {63'b0, hit}, 64'd0);
        clear_all();
    endtask

    task automatic t_sg();
        logic hit; logic [34:0] pa, ra; int nrd, lat;
        wr_csr(2'd2, 2'd0, 64'h8000_0003);
        wr_csr(2'd2, 2'd1, 64'h0010_0000);
        wr_csr(2'd2, 2'd2, 64'h1234_5400);
        xlate(44'h0_8012_3456, 64'h12_3401, hit, pa, nrd, ra, lat);
        chk("R5 entry address", {29'b0, ra}, 64'h1234_5488);
        chk("R12 one read", nrd, 64'd1);
        chk("R5 sg hit", {63'b0, hit}, 64'd1);
        chk("R5 sg address", {29'b0, pa}, 64'h1_2340_1456);
        xlate(44'h0_8012_3456, 64'h12_3400, hit, pa, nrd, ra, lat);
        chk("R6 invalid entry flag", {63'b0, hit}, 64'd0);
        chk("R6 invalid entry address", {29'b0, pa}, 64'h0);
        clear_all();
    endtask

    task automatic t_hole();
        logic hit; logic [34:0] pa, ra; int nrd, lat;
        wr_csr(2'd0, 2'd0, 64'h1);
        wr_csr(2'd0, 2'd2, 64'h5_0000_0000);
        xlate(44'h0_0008_1000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R7 hole off translates", {29'b0, pa}, 64'h5_0008_1000);
        wr_csr(2'd0, 2'd3, 64'h20);
        xlate(44'h0_0008_1000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R7 inside hole", {63'b0, hit}, 64'd0);
        xlate(44'h0_000F_FFFF, 64'h0, hit, pa, nrd, ra, lat);
        chk("R7 hole top", {63'b0, hit}, 64'd0);
        xlate(44'h0_0008_0000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R7 hole bottom", {63'b0, hit}, 64'd0);
        xlate(44'h0_0007_FFFF, 64'h0, hit, pa, nrd, ra, lat);
        chk("R7 below hole", {29'b0, pa}, 64'h5_0007_FFFF);
        clear_all();
    endtask

    task automatic t_win3_dac_monster();
        logic hit; logic [34:0] pa, ra; int nrd, lat;
        wr_csr(2'd3, 2'd0, 64'hC000_0001);
        wr_csr(2'd3, 2'd2, 64'h4_0000);
        xlate(44'h0_C000_6010, 64'hA01, hit, pa, nrd, ra, lat);
        chk("R8 window3 entry address", {29'b0, ra}, 64'h4_0018);
        chk("R8 window3 result", {29'b0, pa}, 64'hA0_0010);
        wr_csr(2'd3, 2'd0, 64'h80_C000_0001);
        xlate(44'h0_C000_6010, 64'hA01, hit, pa, nrd, ra, lat);
        chk("R8 dac bit blocks 32-bit", {63'b0, hit}, 64'd0);
        chk("R8 dac bit no read", nrd, 64'd0);
        wr_csr(2'd3, 2'd2, 64'h1_2340_0000);
        xlate(44'h800_1234_5678, 64'h203, hit, pa, nrd, ra, lat);
        chk("R10 dac entry address", {29'b0, ra}, 64'h1_2344_8D10);
        chk("R10 dac result", {29'b0, pa}, 64'h20_3678);
        wr_csr(2'd3, 2'd0, 64'h80_C000_0000);
        xlate(44'h800_1234_5678, 64'h203, hit, pa, nrd, ra, lat);
        chk("R10 disabled window3 fails", {63'b0, hit}, 64'd0);
        xlate(44'h1AB_CDEF_0123, 64'h0, hit, pa, nrd, ra, lat);
        chk("R9 pass-through off", {63'b0, hit}, 64'd0);
        wr_csr(2'd0, 2'd3, 64'h40);
        xlate(44'h1AB_CDEF_0123, 64'h0, hit, pa, nrd, ra, lat);
        chk("R9 pass-through address", {29'b0, pa}, 64'h3_CDEF_0123);
        chk("R9 pass-through hit", {63'b0, hit}, 64'd1);
        xlate(44'h200_0000_0000, 64'h0, hit, pa, nrd, ra, lat);
        chk("R9 above range", {63'b0, hit}, 64'd0);
        clear_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("[TB] watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_win = '0; cfg_kind = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_csr();
        t_direct_priority();
        t_sg();
        t_hole();
        t_win3_dac_monster();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule